// File: doc/BRIEF.md
# Multiplexed External Data Bus Sequencer

This block runs a single external data-memory access on a bus where the low address byte and the data byte share eight wires. An address-latch strobe lets an outside latch hold the low byte. A high address bus carries the upper byte. Separate active-low read and write strobes time the transfer. A program-fetch strobe is part of the pin set, but it is held inactive throughout. When the sequencer has no request, it presents the program counter in a fetch-address phase. When a request arrives, the access steps through these phases and then returns to that fetch phase.

A request selects a direction and an addressing mode. In wide mode the full 16-bit pointer supplies both address bytes. In narrow mode an 8-bit indirect register supplies the low byte, and the port latch value supplies the high byte. A read returns the byte sampled from the bus. All phase lengths are counted in system clocks.

States, in order: `PH_IDLE` (fetch address) → `PH_ADDR` on an accepted request → `PH_LATCH` when the address count ends → `PH_SETUP` → `PH_STRB` → `PH_RECOV` when the strobe count ends → `PH_IDLE` when the recovery count ends.

Top module: `xbus_seq`

## Requirements
- R1: During and after reset the block is in PH_IDLE. In PH_IDLE the outputs are: ale=1, bus_lo_oe=1, bus_lo_out=pc[7:0], bus_hi=pc[15:8], rd_n=1, wr_n=1, done=0, idle=1, and rdata=0 until the first read.
- R2: A request (req_valid=1 at a rising edge) is taken only in PH_IDLE. req_valid in any other phase has no effect on any output, and the captured request fields stay unchanged.
- R3: After acceptance the following holds for ADDR_CLKS clocks: ale=1, bus_lo_oe=1, rd_n=wr_n=1. bus_lo_out is req_addr[7:0] when req_wide=1, otherwise req_ind_addr. bus_hi is req_addr[15:8] when req_wide=1, otherwise port_hi. All of these values are captured at acceptance.
- R4: For one PH_LATCH clock, ale=0 while the low address is still driven with bus_lo_oe=1. A strobe falls only after ale has been low for at least one clock.
- R5: In a read (req_write=0), bus_lo_oe=0 and bus_lo_out=0 from PH_SETUP through the end of PH_RECOV. rd_n=0 for exactly STRB_CLKS clocks, and bus_hi holds the high address byte.
- R6: In the last rd_n-low clock, bus_lo_in is sampled. That byte appears on rdata from the next clock and is held until the next read samples.
- R7: In a write (req_write=1), bus_lo_out=req_wdata with bus_lo_oe=1 from PH_SETUP, one clock before wr_n falls. It stays that way through all RECOV_CLKS clocks after wr_n rises. wr_n=0 for exactly STRB_CLKS clocks.
- R8: PH_RECOV lasts RECOV_CLKS clocks with both strobes high and ale=0. done=1 only in its last clock, and the next clock is PH_IDLE with ale=1.
- R9: fetch_n stays 1 at all times.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Access request, sampled in PH_IDLE |
| req_write | input | 1 | 1 = write, 0 = read |
| req_wide | input | 1 | 1 = 16-bit pointer mode, 0 = 8-bit indirect mode |
| req_addr | input | 16 | 16-bit pointer |
| req_ind_addr | input | 8 | Indirect register address |
| port_hi | input | 8 | Port latch value used as high byte in indirect mode |
| req_wdata | input | 8 | Write data byte |
| pc | input | 16 | Program counter shown in the fetch phase |
| bus_lo_in | input | 8 | Low bus input from the pads |
| ale | output | 1 | Address-latch strobe, active high |
| bus_lo_out | output | 8 | Low bus output value |
| bus_lo_oe | output | 1 | Low bus output enable |
| bus_hi | output | 8 | High address bus |
| rd_n | output | 1 | Read strobe, active low |
| wr_n | output | 1 | Write strobe, active low |
| fetch_n | output | 1 | Program-fetch strobe, held inactive |
| rdata | output | 8 | Last byte read |
| done | output | 1 | One-clock pulse in the final clock of an access |
| idle | output | 1 | High in PH_IDLE |

## Verification
Every output is a direct function of the phase and the phase counter. A wrong state or a counter that is off by one therefore shows up in the same clock: ale, a strobe or bus_lo_oe takes the wrong level, or done appears one clock early or late. A bad capture register shows up as a wrong byte on bus_lo_out or bus_hi within one clock of acceptance. A wrong read sample is seen on rdata one clock after the strobe ends. The bench model is stepped on every clock and compared with every output on every clock, so any such error is reported in the clock where it first appears.

// File: rtl/xbus_pkg.sv
package xbus_pkg;

    typedef enum logic [2:0] {
        PH_IDLE  = 3'd0,
        PH_ADDR  = 3'd1,
        PH_LATCH = 3'd2,
        PH_SETUP = 3'd3,
        PH_STRB  = 3'd4,
        PH_RECOV = 3'd5
    } phase_e;

endpackage

// File: rtl/xbus_ph_timer.sv
module xbus_ph_timer #(
    parameter int CW = 3
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic [CW-1:0] load_val,
    output logic          last
);

    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (load) begin
            cnt_q <= load_val;
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    assign last = (cnt_q == '0);

    // the count never rises except on a load
    p_cnt_down_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(load) |-> (cnt_q <= $past(cnt_q)));

endmodule

// File: rtl/xbus_drive.sv
module xbus_drive
    import xbus_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  phase_e      phase,
    input  logic        is_wr,
    input  logic [7:0]  a_lo,
    input  logic [7:0]  a_hi,
    input  logic [7:0]  wdata,
    input  logic [15:0] pc,
    output logic        ale,
    output logic [7:0]  lo_out,
    output logic        lo_oe,
    output logic [7:0]  hi_out,
    output logic        rd_n,
    output logic        wr_n,
    output logic        fetch_n
);

    always_comb begin
        ale     = 1'b0;
        lo_out  = 8'h00;
        lo_oe   = 1'b0;
        hi_out  = a_hi;
        rd_n    = 1'b1;
        wr_n    = 1'b1;
        fetch_n = 1'b1;
        unique case (phase)
            PH_IDLE: begin
                ale    = 1'b1;
                lo_out = pc[7:0];
                lo_oe  = 1'b1;
                hi_out = pc[15:8];
            end
            PH_ADDR: begin
                ale    = 1'b1;
                lo_out = a_lo;
                lo_oe  = 1'b1;
            end
            PH_LATCH: begin
                lo_out = a_lo;
                lo_oe  = 1'b1;
            end
            PH_SETUP, PH_RECOV: begin
                lo_out = is_wr ? wdata : 8'h00;
                lo_oe  = is_wr;
            end
            PH_STRB: begin
                lo_out = is_wr ? wdata : 8'h00;
                lo_oe  = is_wr;
                rd_n   = is_wr;
                wr_n   = !is_wr;
            end
            default: begin
                ale = 1'b0;
            end
        endcase
    end

    p_strobe_after_latch_r4: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(rd_n) || $fell(wr_n)) |-> (!ale && !$past(ale)));

    p_read_release_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_n |-> !lo_oe);

    p_write_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(wr_n) |-> (lo_oe && $stable(lo_out)));

    p_one_strobe_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $countones({rd_n, wr_n}) >= 1);

    p_fetch_inactive_r9: assert property (@(posedge clk) disable iff (!rst_n)
        fetch_n);

endmodule

// File: rtl/xbus_seq.sv
module xbus_seq
    import xbus_pkg::*;
#(
    parameter int ADDR_CLKS  = 3,
    parameter int STRB_CLKS  = 6,
    parameter int RECOV_CLKS = 3
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        req_valid,
    input  logic        req_write,
    input  logic        req_wide,
    input  logic [15:0] req_addr,
    input  logic [7:0]  req_ind_addr,
    input  logic [7:0]  port_hi,
    input  logic [7:0]  req_wdata,
    input  logic [15:0] pc,
    input  logic [7:0]  bus_lo_in,
    output logic        ale,
    output logic [7:0]  bus_lo_out,
    output logic        bus_lo_oe,
    output logic [7:0]  bus_hi,
    output logic        rd_n,
    output logic        wr_n,
    output logic        fetch_n,
    output logic [7:0]  rdata,
    output logic        done,
    output logic        idle
);

    localparam int MAX_AS = (ADDR_CLKS > STRB_CLKS) ? ADDR_CLKS : STRB_CLKS;
    localparam int MAX_C  = (MAX_AS > RECOV_CLKS) ? MAX_AS : RECOV_CLKS;
    localparam int CW     = (MAX_C < 2) ? 1 : $clog2(MAX_C);

    phase_e        state_q, state_n;
    logic          last;
    logic          load;
    logic [CW-1:0] load_val;
    logic          wr_q;
    logic [7:0]    a_lo_q, a_hi_q, wd_q, rdata_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= PH_IDLE;
        else        state_q <= state_n;
    end

    always_comb begin
        state_n = state_q;
        unique case (state_q)
            PH_IDLE:  if (req_valid) state_n = PH_ADDR;
            PH_ADDR:  if (last)      state_n = PH_LATCH;
            PH_LATCH:                state_n = PH_SETUP;
            PH_SETUP:                state_n = PH_STRB;
            PH_STRB:  if (last)      state_n = PH_RECOV;
            PH_RECOV: if (last)      state_n = PH_IDLE;
            default:                 state_n = PH_IDLE;
        endcase
    end

    always_comb begin
        load = (state_n != state_q);
        unique case (state_n)
            PH_ADDR:  load_val = CW'(ADDR_CLKS - 1);
            PH_STRB:  load_val = CW'(STRB_CLKS - 1);
            PH_RECOV: load_val = CW'(RECOV_CLKS - 1);
            default:  load_val = '0;
        endcase
    end

    xbus_ph_timer #(.CW(CW)) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (load),
        .load_val (load_val),
        .last     (last)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wr_q   <= 1'b0;
            a_lo_q <= 8'h00;
            a_hi_q <= 8'h00;
            wd_q   <= 8'h00;
        end else if (state_q == PH_IDLE && req_valid) begin
            wr_q   <= req_write;
            a_lo_q <= req_wide ? req_addr[7:0]  : req_ind_addr;
            a_hi_q <= req_wide ? req_addr[15:8] : port_hi;
            wd_q   <= req_wdata;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                                  rdata_q <= 8'h00;
        else if (state_q == PH_STRB && last && !wr_q) rdata_q <= bus_lo_in;
    end

    xbus_drive u_drive (
        .clk     (clk),
        .rst_n   (rst_n),
        .phase   (state_q),
        .is_wr   (wr_q),
        .a_lo    (a_lo_q),
        .a_hi    (a_hi_q),
        .wdata   (wd_q),
        .pc      (pc),
        .ale     (ale),
        .lo_out  (bus_lo_out),
        .lo_oe   (bus_lo_oe),
        .hi_out  (bus_hi),
        .rd_n    (rd_n),
        .wr_n    (wr_n),
        .fetch_n (fetch_n)
    );

    assign rdata = rdata_q;
    assign done  = (state_q == PH_RECOV) && last;
    assign idle  = (state_q == PH_IDLE);

    p_req_held_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (!idle && !$past(idle)) |-> ($stable(a_lo_q) && $stable(a_hi_q) && $stable(wd_q) && $stable(wr_q)));

    p_done_then_fetch_r8: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> (idle && ale && !done));

    p_done_from_recov_r8: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (rd_n && wr_n && !ale));

endmodule

// File: tb/xbus_seq_tb.sv
module xbus_seq_tb;

    localparam int TA  = 3;
    localparam int TS  = 6;
    localparam int TR  = 3;
    localparam int TOT = TA + 2 + TS + TR;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0, req_write = 1'b0, req_wide = 1'b0;
    logic [15:0] req_addr = 16'h0, pc = 16'h1234;
    logic [7:0]  req_ind_addr = 8'h0, port_hi = 8'h0, req_wdata = 8'h0, bus_lo_in = 8'h0;
    logic        ale, bus_lo_oe, rd_n, wr_n, fetch_n, done, idle;
    logic [7:0]  bus_lo_out, bus_hi, rdata;

    int  total = 0;
    int  bad = 0;
    bit  ended = 0;
    int  dones_seen = 0;
    int  dones_exp = 0;

    // reference model state
    int         pos = -1;
    bit         m_wr;
    logic [7:0] m_lo, m_hi, m_wd, m_rd = 8'h00;

    always #2 clk = ~clk;

    xbus_seq #(.ADDR_CLKS(TA), .STRB_CLKS(TS), .RECOV_CLKS(TR)) u_dut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
        .req_wide(req_wide), .req_addr(req_addr), .req_ind_addr(req_ind_addr),
        .port_hi(port_hi), .req_wdata(req_wdata), .pc(pc), .bus_lo_in(bus_lo_in),
        .ale(ale), .bus_lo_out(bus_lo_out), .bus_lo_oe(bus_lo_oe), .bus_hi(bus_hi),
        .rd_n(rd_n), .wr_n(wr_n), .fetch_n(fetch_n), .rdata(rdata), .done(done), .idle(idle)
    );

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pos  = -1;
            m_rd = 8'h00;
        end else if (pos < 0) begin
            if (req_valid) begin
                pos  = 0;
                m_wr = req_write;
                m_lo = req_wide ? req_addr[7:0] : req_ind_addr;
                m_hi = req_wide ? req_addr[15:8] : port_hi;
                m_wd = req_wdata;
            end
        end else begin
            if (pos == TA + 1 + TS && !m_wr) m_rd = bus_lo_in;
            if (pos == TOT - 1) begin
                pos = -1;
                dones_exp++;
            end else pos++;
        end
    end

    always @(posedge clk) begin
        #1 bus_lo_in = 8'($urandom);
    end

    task automatic chk(input string tag, input string nm, input int act, input int exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s %s act=%0h exp=%0h t=%0t", tag, nm, act, exp, $time);
        end
    endtask

    always @(negedge clk) begin
        string tg;
        bit    strb, late;
        strb = (pos >= TA + 2) && (pos < TA + 2 + TS);
        late = (pos >= TA + 1);
        if (pos < 0)                tg = "R1";
        else if (req_valid)         tg = "R2";
        else if (pos < TA)          tg = "R3";
        else if (pos == TA)         tg = "R4";
        else if (pos >= TA + 2 + TS) tg = "R8";
        else                        tg = m_wr ? "R7" : "R5";
        if (done) dones_seen++;
        chk("R9", "fetch_n", fetch_n, 1);
        chk("R6", "rdata", rdata, m_rd);
        chk("R8", "done", done, (pos == TOT - 1));
        chk(tg, "idle", idle, (pos < 0));
        if (pos < 0) begin
            chk(tg, "ale", ale, 1);
            chk(tg, "lo_oe", bus_lo_oe, 1);
            chk(tg, "lo_out", bus_lo_out, pc[7:0]);
            chk(tg, "hi", bus_hi, pc[15:8]);
            chk(tg, "rd_n", rd_n, 1);
            chk(tg, "wr_n", wr_n, 1);
        end else begin
            chk(tg, "ale", ale, (pos < TA));
            chk(tg, "hi", bus_hi, m_hi);
            chk(tg, "rd_n", rd_n, !(strb && !m_wr));
            chk(tg, "wr_n", wr_n, !(strb && m_wr));
            chk(tg, "lo_oe", bus_lo_oe, late ? m_wr : 1);
            chk(tg, "lo_out", bus_lo_out, late ? (m_wr ? m_wd : 0) : m_lo);
        end
    end

    task automatic finish_up();
        if (!ended) begin
            ended = 1;
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    endtask

    task automatic tick(input int n);
        for (int i = 0; i < n; i++) begin
            @(posedge clk);
            #1;
        end
    endtask

    task automatic access(input bit wr, input bit wide, input logic [15:0] a,
                          input logic [7:0] ind, input logic [7:0] ph, input logic [7:0] wd);
        req_valid = 1; req_write = wr; req_wide = wide; req_addr = a;
        req_ind_addr = ind; port_hi = ph; req_wdata = wd;
        tick(1);
        req_valid = 0;
        req_addr = ~a; req_ind_addr = ~ind; port_hi = ~ph; req_wdata = ~wd;
        tick(TOT + 1);
    endtask

    initial begin
        tick(3);
        rst_n = 1;
        tick(2);
        pc = 16'hA55A;
        tick(2);
        access(1, 1, 16'h12A5, 8'h00, 8'h00, 8'h3C);   // R7 wide write
        access(0, 1, 16'hBEEF, 8'h00, 8'h00, 8'h00);   // R5 R6 wide read
        pc = 16'h0F0E;
        access(0, 0, 16'hFFFF, 8'h44, 8'h9D, 8'h00);   // R3 narrow read
        access(1, 0, 16'h0000, 8'h81, 8'h27, 8'hC6);   // R3 R7 narrow write
        // R2: request held high for many clocks with changing fields
        req_valid = 1; req_write = 0; req_wide = 1;
        for (int i = 0; i < 2 * TOT + 5; i++) begin
            req_addr = 16'(i * 16'h0101 + 16'h0302);
            req_wdata = 8'(i);
            req_write = i[0];
            tick(1);
        end
        req_valid = 0;
        tick(TOT + 2);
        for (int k = 0; k < 8; k++) begin
            access(1'($urandom), 1'($urandom), 16'($urandom), 8'($urandom),
                   8'($urandom), 8'($urandom));
            tick(k % 3);
        end
        chk("R2", "done_count", dones_seen, dones_exp);
        chk("R8", "done_count_min", (dones_seen >= 14), 1);
        finish_up();
    end

    initial begin
        repeat (100000) @(posedge clk);
        bad++;
        $display("FAIL watchdog expired");
        finish_up();
    end

endmodule